// File: doc/BRIEF.md
# Two-Bit Reduced-Pin Ethernet Frame Transmitter

This block sends one Ethernet frame at a time on a 2-bit reduced-pin (RMII) transmit interface. Software fills a byte-wide transmit buffer and programs a length value and a launch-phase value. It then pulses `start_i`. The block sends a preamble and a start-of-frame delimiter, then reads the payload from the buffer in address order and sends it. It always appends a CRC-32 frame check sequence. When the transmit enable has dropped, it pulses `done_o`.

The whole block runs on one clock at four times the 50 MHz line rate. A free-running divide-by-four produces the 50 MHz reference, which leaves the block on `ref_clk_o`. One dibit is produced per reference period. A retiming register launches the data and enable lines at one of four quarter-period offsets after the reference rising edge. This setting gives the far-end receiver enough setup margin that it never samples the previous dibit.

The length value counts one more than the number of payload bytes. The phase value is captured when a frame is accepted, so it only changes between frames.

Top module: `rmii_frame_tx`

## Requirements
- R1: During reset and after it, with no frame started, `txd_o`, `tx_en_o`, `busy_o` and `done_o` are all low.
- R2: `ref_clk_o` has a period of four `clk_i` cycles. It is high for two cycles and low for two.
- R3: `start_i` is accepted only when `busy_o` is low, and `busy_o` is high in the following cycle. `len_i` and `phase_i` are captured at acceptance. A `start_i` while busy has no effect on the frame in progress.
- R4: Each dibit is held on `txd_o` for one full reference period. A byte goes out as four dibits, bits [1:0] first and bits [7:6] last, with the lower bit of each pair on `txd_o[0]`. A frame opens with seven bytes of 0x55 followed by 0xD5.
- R5: After the delimiter, the payload bytes at buffer addresses 0 up to `len_i`-2 are sent in order, which is `len_i`-1 bytes. A `len_i` of 0 or 1 sends no payload. The buffer returns `rd_data_i` for `rd_addr_o` one clock later.
- R6: Four check bytes follow the payload. They are the CRC-32 over the payload only: reflected polynomial 0xEDB88320 (0x04C11DB7 bit-reversed), preset to all ones, with the final remainder inverted. They are sent least significant bit first, bit 2k on `txd_o[0]` and bit 2k+1 on `txd_o[1]`.
- R7: The CRC remainder is not updated while the check bytes are shifted out, so all 16 check dibits come from the same final remainder.
- R8: `txd_o` and `tx_en_o` change only on the `clk_i` edge that comes p cycles (p × 5 ns) after the edge on which `ref_clk_o` rises, where p is the captured phase value 0 to 3.
- R9: `tx_en_o` is high for exactly 4 × (12 + payload bytes) reference periods. It drops in the period after the last check dibit. `txd_o` is 0 whenever `tx_en_o` is low.
- R10: `done_o` is a one-cycle pulse in the cycle after `tx_en_o` falls, with `busy_o` low in that cycle. A `start_i` in that same cycle is accepted, so frames can follow each other directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 200 MHz clock, four times the line rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to send one frame |
| len_i | input | LEN_W | Payload byte count plus one |
| phase_i | input | 2 | Launch offset in quarter reference periods |
| rd_addr_o | output | LEN_W | Transmit buffer read address |
| rd_data_i | input | 8 | Transmit buffer data, one cycle after the address |
| ref_clk_o | output | 1 | 50 MHz reference derived from `clk_i` |
| txd_o | output | 2 | Transmit dibit |
| tx_en_o | output | 1 | Transmit enable |
| busy_o | output | 1 | Frame accepted and not yet finished |
| done_o | output | 1 | One-cycle pulse when a frame has finished |

## Verification
Two events can fall in the same cycle: the `done_o` pulse that ends one frame and the acceptance of the next `start_i`, with a new launch phase. The bench provokes this by raising `start_i` in exactly the cycle in which it sees `done_o`. It checks that `busy_o` is high in the next cycle. Its scoreboard then checks that the second frame has its own dibit stream and its own launch offset, measured from the rise of `ref_clk_o`, and that the first frame's tail is unchanged.

// File: rtl/rmii_tx_pkg.sv
`timescale 1ns/1ps
package rmii_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_FCS,
    ST_END,
    ST_DRAIN
  } tx_state_e;

  localparam int          CRC_W       = 32;
  localparam logic [31:0] CRC_POLY    = 32'hEDB8_8320;
  localparam logic [31:0] CRC_PRESET  = 32'hFFFF_FFFF;
  localparam logic [7:0]  PRE_BYTE    = 8'h55;
  localparam logic [7:0]  SFD_BYTE    = 8'hD5;
  localparam int          PRE_BYTES   = 8;
  localparam int          FCS_BYTES   = 4;

endpackage

// File: rtl/rmii_crc32_dibit.sv
`timescale 1ns/1ps
module rmii_crc32_dibit
  import rmii_tx_pkg::*;
#(
  parameter int DW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic          valid_i,
  input  logic          shift_i,
  input  logic [DW-1:0] dibit_i,
  output logic [DW-1:0] fcs_dibit_o
);

  logic [CRC_W-1:0]         crc_q;
  logic [DW:0][CRC_W-1:0]   stage;

  assign stage[0] = crc_q;

  // one reflected LFSR step per input bit, bit 0 first
  for (genvar g = 0; g < DW; g++) begin : g_step
    assign stage[g+1] = {1'b0, stage[g][CRC_W-1:1]}
                      ^ ({CRC_W{stage[g][0] ^ dibit_i[g]}} & CRC_POLY);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_PRESET;
    else if (init_i)  crc_q <= CRC_PRESET;
    else if (valid_i) crc_q <= stage[DW];
    else if (shift_i) crc_q <= {{DW{1'b1}}, crc_q[CRC_W-1:DW]};
  end

  // low remainder bit goes to lane 0
  assign fcs_dibit_o = ~crc_q[DW-1:0];

  assert_fcs_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && shift_i));

  assert_init_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |-> !shift_i);

endmodule

// File: rtl/rmii_tx_launch.sv
`timescale 1ns/1ps
module rmii_tx_launch #(
  parameter int DW   = 2,
  parameter int PH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_phase_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic [DW-1:0]   dibit_i,
  input  logic            en_i,
  output logic            tick_o,
  output logic            ref_clk_o,
  output logic [DW-1:0]   txd_o,
  output logic            tx_en_o
);

  localparam int RATIO   = 1 << PH_W;
  localparam int TICK_PH = RATIO - 2;

  logic [PH_W-1:0] ph_cnt_q;
  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] cap_ph;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_cnt_q <= '0;
    else         ph_cnt_q <= ph_cnt_q + PH_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           phase_q <= '0;
    else if (load_phase_i) phase_q <= phase_i;
  end

  assign tick_o    = (ph_cnt_q == PH_W'(TICK_PH));
  assign ref_clk_o = (ph_cnt_q < PH_W'(RATIO / 2));
  // sequencer output is stable from TICK_PH+1 for RATIO cycles
  assign cap_ph    = phase_q + PH_W'(RATIO - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_o   <= '0;
      tx_en_o <= 1'b0;
    end else if (ph_cnt_q == cap_ph) begin
      txd_o   <= en_i ? dibit_i : '0;
      tx_en_o <= en_i;
    end
  end

  assert_launch_offset_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({txd_o, tx_en_o}) |-> (ph_cnt_q == phase_q));

  assert_idle_lines_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> (txd_o == '0));

  assert_ref_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ref_clk_o) |=> ref_clk_o);

  assert_ref_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ref_clk_o) |=> !ref_clk_o);

endmodule

// File: rtl/rmii_tx_seq.sv
`timescale 1ns/1ps
module rmii_tx_seq
  import rmii_tx_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int DW    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             line_en_i,
  output logic [LEN_W-1:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic             crc_init_o,
  output logic             crc_valid_o,
  output logic             crc_shift_o,
  output logic [DW-1:0]    crc_dibit_o,
  input  logic [DW-1:0]    fcs_dibit_i,
  output logic [DW-1:0]    dibit_o,
  output logic             en_o,
  output logic             accept_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int DIB_PER_BYTE = 8 / DW;
  localparam int DIB_W        = $clog2(DIB_PER_BYTE);
  localparam int PRE_DIBITS   = PRE_BYTES * DIB_PER_BYTE;
  localparam int FCS_DIBITS   = FCS_BYTES * DIB_PER_BYTE;
  localparam int CNT_W        = $clog2(PRE_DIBITS);

  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_DIBITS - 1);
  localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(FCS_DIBITS - 1);
  localparam logic [DIB_W-1:0] DIB_LAST = DIB_W'(DIB_PER_BYTE - 1);

  tx_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] addr_q;
  logic [LEN_W-1:0] npay_q;
  logic [7:0]       cur_byte_q;
  logic [DW-1:0]    dibit_q;
  logic             en_q;
  logic             done_q;

  logic [DIB_W-1:0] dib_idx;
  logic [7:0]       pre_byte;
  logic [7:0]       data_byte;
  logic [DW-1:0]    pre_dibit;
  logic [DW-1:0]    data_dibit;
  logic             accept;

  assign dib_idx    = cnt_q[DIB_W-1:0];
  assign pre_byte   = (cnt_q[CNT_W-1:DIB_W] == (CNT_W-DIB_W)'(PRE_BYTES - 1)) ? SFD_BYTE : PRE_BYTE;
  assign pre_dibit  = pre_byte[dib_idx*DW +: DW];
  // first dibit of a byte comes straight from the buffer
  assign data_byte  = (dib_idx == '0) ? rd_data_i : cur_byte_q;
  assign data_dibit = data_byte[dib_idx*DW +: DW];
  assign accept     = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      addr_q     <= '0;
      npay_q     <= '0;
      cur_byte_q <= '0;
      dibit_q    <= '0;
      en_q       <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          npay_q  <= (len_i == '0) ? '0 : len_i - LEN_W'(1);
          addr_q  <= '0;
          cnt_q   <= '0;
          state_q <= ST_PRE;
        end
        ST_PRE: if (tick_i) begin
          dibit_q <= pre_dibit;
          en_q    <= 1'b1;
          cnt_q   <= cnt_q + CNT_W'(1);
          if (cnt_q == PRE_LAST) begin
            cnt_q   <= '0;
            state_q <= (npay_q == '0) ? ST_FCS : ST_DATA;
          end
        end
        ST_DATA: if (tick_i) begin
          dibit_q <= data_dibit;
          cnt_q   <= cnt_q + CNT_W'(1);
          if (dib_idx == '0) begin
            cur_byte_q <= rd_data_i;
            addr_q     <= addr_q + LEN_W'(1);
          end
          if (dib_idx == DIB_LAST) begin
            cnt_q <= '0;
            if (addr_q == npay_q) state_q <= ST_FCS;
          end
        end
        ST_FCS: if (tick_i) begin
          dibit_q <= fcs_dibit_i;
          cnt_q   <= cnt_q + CNT_W'(1);
          if (cnt_q == FCS_LAST) begin
            cnt_q   <= '0;
            state_q <= ST_END;
          end
        end
        ST_END: if (tick_i) begin
          dibit_q <= '0;
          en_q    <= 1'b0;
          state_q <= ST_DRAIN;
        end
        ST_DRAIN: if (!line_en_i) begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_addr_o   = addr_q;
  assign crc_init_o  = accept;
  assign crc_valid_o = tick_i && (state_q == ST_DATA);
  assign crc_shift_o = tick_i && (state_q == ST_FCS);
  assign crc_dibit_o = data_dibit;
  assign dibit_o     = dibit_q;
  assign en_o        = en_q;
  assign accept_o    = accept;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;

  assert_payload_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FCS && $past(state_q) == ST_DATA) |-> (addr_q == npay_q));

  assert_start_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(npay_q));

  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_fall_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !line_en_i);

endmodule

// File: rtl/rmii_frame_tx.sv
`timescale 1ns/1ps
module rmii_frame_tx #(
  parameter int LEN_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [1:0]       phase_i,
  output logic [LEN_W-1:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic             ref_clk_o,
  output logic [1:0]       txd_o,
  output logic             tx_en_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int DW   = 2;
  localparam int PH_W = 2;

  logic          tick;
  logic          accept;
  logic          crc_init;
  logic          crc_valid;
  logic          crc_shift;
  logic [DW-1:0] crc_dibit;
  logic [DW-1:0] fcs_dibit;
  logic [DW-1:0] seq_dibit;
  logic          seq_en;

  rmii_tx_seq #(
    .LEN_W (LEN_W),
    .DW    (DW)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .start_i     (start_i),
    .len_i       (len_i),
    .line_en_i   (tx_en_o),
    .rd_addr_o   (rd_addr_o),
    .rd_data_i   (rd_data_i),
    .crc_init_o  (crc_init),
    .crc_valid_o (crc_valid),
    .crc_shift_o (crc_shift),
    .crc_dibit_o (crc_dibit),
    .fcs_dibit_i (fcs_dibit),
    .dibit_o     (seq_dibit),
    .en_o        (seq_en),
    .accept_o    (accept),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  rmii_crc32_dibit #(
    .DW (DW)
  ) u_crc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (crc_init),
    .valid_i     (crc_valid),
    .shift_i     (crc_shift),
    .dibit_i     (crc_dibit),
    .fcs_dibit_o (fcs_dibit)
  );

  rmii_tx_launch #(
    .DW   (DW),
    .PH_W (PH_W)
  ) u_launch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_phase_i (accept),
    .phase_i      (phase_i),
    .dibit_i      (seq_dibit),
    .en_i         (seq_en),
    .tick_o       (tick),
    .ref_clk_o    (ref_clk_o),
    .txd_o        (txd_o),
    .tx_en_o      (tx_en_o)
  );

endmodule

// File: tb/rmii_frame_tx_tb.sv
`timescale 1ns/1ps
module rmii_frame_tx_tb;

  localparam int CLK_PERIOD = 5;
  localparam int LEN_W      = 11;
  localparam int WDOG       = 100000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [LEN_W-1:0] len = '0;
  logic [1:0]       phase = '0;
  logic [LEN_W-1:0] rd_addr;
  logic [7:0]       rd_data;
  logic             ref_clk;
  logic [1:0]       txd;
  logic             tx_en;
  logic             busy;
  logic             done;

  logic [7:0] mem [0:255];

  int checks = 0;
  int errors = 0;
  int done_seen = 0;
  int frames = 0;
  bit finished = 0;

  logic [1:0] exp_q[$];
  string      exp_tag_q[$];
  int         exp_len_q[$];
  int         exp_ph_q[$];

  always #(CLK_PERIOD/2.0) clk = ~clk;

  always_ff @(posedge clk) rd_data <= mem[rd_addr[7:0]];

  rmii_frame_tx #(.LEN_W(LEN_W)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .start_i   (start),
    .len_i     (len),
    .phase_i   (phase),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data),
    .ref_clk_o (ref_clk),
    .txd_o     (txd),
    .tx_en_o   (tx_en),
    .busy_o    (busy),
    .done_o    (done)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] crc_byte(logic [31:0] c, logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = c[0] ^ b[i];
      c  = c >> 1;
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c;
  endfunction

  task automatic push_byte(logic [7:0] b, string tag);
    for (int i = 0; i < 4; i++) begin
      exp_q.push_back(b[2*i +: 2]);
      exp_tag_q.push_back(tag);
    end
  endtask

  // driver side of the scoreboard
  task automatic push_frame(int l, int ph);
    int nb;
    logic [31:0] c;
    logic [31:0] fcs;
    nb = (l <= 1) ? 0 : l - 1;
    for (int i = 0; i < 7; i++) push_byte(8'h55, "R4");
    push_byte(8'hD5, "R4");
    c = 32'hFFFFFFFF;
    for (int i = 0; i < nb; i++) begin
      push_byte(mem[i], "R5");
      c = crc_byte(c, mem[i]);
    end
    fcs = ~c;
    for (int i = 0; i < 16; i++) begin
      exp_q.push_back(fcs[2*i +: 2]);
      exp_tag_q.push_back(i == 0 ? "R6" : "R7");
    end
    exp_len_q.push_back(4 * (12 + nb));
    exp_ph_q.push_back(ph);
    frames++;
  endtask

  // monitor side
  int         k = 0;
  logic       ref_prev = 1'b0;
  bit         in_frame = 0;
  bit         expect_done = 0;
  int         wait_n = 0;
  int         dib_n = 0;
  int         cur_ph = 0;
  logic [2:0] last = '0;

  task automatic take_sample();
    logic [1:0] e;
    string t;
    if (exp_q.size() == 0) begin
      check(0, "R9 extra dibit", int'(txd), 0);
    end else begin
      e = exp_q.pop_front();
      t = exp_tag_q.pop_front();
      check(txd == e, t, int'(txd), int'(e));
    end
    dib_n++;
    last = {txd, tx_en};
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (ref_clk && !ref_prev) k = 0;
      else k = (k + 1) % 4;
      ref_prev = ref_clk;
      if (expect_done) begin
        check(done && !busy, "R10 done pulse", int'({done, busy}), 2);
        if (done) done_seen++;
        expect_done = 0;
      end else if (done) begin
        check(0, "R10 unexpected done", 1, 0);
      end
      if (!in_frame) begin
        if (tx_en) begin
          cur_ph = (exp_ph_q.size() != 0) ? exp_ph_q.pop_front() : -1;
          check(k == cur_ph, "R8 start offset", k, cur_ph);
          in_frame = 1;
          wait_n   = 0;
          dib_n    = 0;
          take_sample();
        end else begin
          check(txd == 2'b00, "R9 idle txd", int'(txd), 0);
        end
      end else begin
        wait_n++;
        if (wait_n == 4) begin
          wait_n = 0;
          if (tx_en) begin
            check(k == cur_ph, "R8 dibit offset", k, cur_ph);
            take_sample();
          end else begin
            int el;
            el = (exp_len_q.size() != 0) ? exp_len_q.pop_front() : -1;
            check(k == cur_ph, "R8 end offset", k, cur_ph);
            check(dib_n == el, "R9 frame dibits", dib_n, el);
            check(txd == 2'b00, "R9 txd after end", int'(txd), 0);
            in_frame    = 0;
            expect_done = 1;
          end
        end else begin
          check({txd, tx_en} == last, "R4 dibit held", int'({txd, tx_en}), int'(last));
        end
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic kick(int l, int ph);
    start = 1'b1;
    len   = LEN_W'(l);
    phase = 2'(ph);
    @(negedge clk);
    start = 1'b0;
    check(busy, "R3 accepted", int'(busy), 1);
  endtask

  initial begin
    logic [31:0] c;
    logic [7:0]  s [9];
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);

    // R1 reset state, during and after reset
    repeat (3) @(negedge clk);
    check({txd, tx_en, busy, done} == 5'b0, "R1 in reset", int'({txd, tx_en, busy, done}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check({txd, tx_en, busy, done} == 5'b0, "R1 after reset", int'({txd, tx_en, busy, done}), 0);

    // R2 reference clock shape
    begin
      logic r [12];
      for (int i = 0; i < 12; i++) begin
        r[i] = ref_clk;
        @(negedge clk);
      end
      for (int i = 0; i < 8; i++) begin
        check(r[i] == r[i+4], "R2 period", int'(r[i+4]), int'(r[i]));
        check(r[i] != r[i+2], "R2 duty", int'(r[i+2]), int'(!r[i]));
      end
    end

    // R6 bench CRC sanity against the standard check value
    s = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 9; i++) c = crc_byte(c, s[i]);
    check(~c == 32'hCBF43926, "R6 crc model", int'(~c), 32'hCBF43926);

    // R4 R5 R6 R7: 8-byte payload, phase 0
    push_frame(9, 0);
    kick(9, 0);
    wait_done();
    repeat (7) @(negedge clk);

    // R5: length 1 sends no payload, phase 2
    push_frame(1, 2);
    kick(1, 2);
    wait_done();
    repeat (5) @(negedge clk);

    // R5: length 0 also sends no payload, phase 3
    for (int i = 0; i < 4; i++) mem[i] = 8'hA0 + 8'(i);
    push_frame(0, 3);
    kick(0, 3);
    wait_done();
    repeat (3) @(negedge clk);

    // R3: a start while busy is ignored
    push_frame(21, 3);
    kick(21, 3);
    repeat (100) @(negedge clk);
    start = 1'b1;
    len   = LEN_W'(50);
    phase = 2'd1;
    @(negedge clk);
    start = 1'b0;
    check(busy, "R3 still busy", int'(busy), 1);
    wait_done();
    repeat (9) @(negedge clk);

    // R10: next start in the done cycle, with a new phase
    push_frame(6, 1);
    push_frame(3, 2);
    kick(6, 1);
    wait_done();
    kick(3, 2);
    wait_done();
    repeat (10) @(negedge clk);

    check(done_seen == frames, "R10 done count", done_seen, frames);
    check(exp_q.size() == 0, "R9 all dibits seen", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule